// File: doc/BRIEF.md
# EEPROM / Register Transaction Sequencer

This block turns one request (probe, write or read of a register-addressed I2C device) into the ordered list of bus primitives that a separate byte engine executes: start condition, stop condition, write a byte and sample its acknowledge, or read a byte and return an acknowledge or not-acknowledge. The host supplies a 7-bit device address, a register address of zero to four bytes, a byte count and the operation. Write data comes in on a byte-wide valid/ready stream, read data leaves on another. A one-cycle `done` pulse with an error flag and a failure count closes every transaction.

Two build-time choices adapt it to awkward parts. With a non-zero `OVF_MASK`, register-address bits that lie above the transmitted address bytes are merged into the low device-address bits. This suits memories that hide extra address bits in the device address. `REP_START` selects how a read turns from the address phase to the data phase: a stop followed by a start, or a repeated start alone.

Top module: `eeprom_txn_seq`

## Requirements
- R1: `opSel` 0 (or 3) is a probe. It issues start, writes `{chip,0}`, then stop. `errNack` at `done` is 1 exactly when that byte was not acknowledged.
- R2: For writes, and for reads with `addrLen` > 0, the device byte `{chip,0}` is followed by `addrLen` register-address bytes, most significant byte first.
- R3: A read (`opSel` 2) with `addrLen` = 0 has no addressing phase. It issues start and then `{chip,1}` directly.
- R4: A read writes `{chip,1}` and then issues `byteCount` reads. `engSendNack` is 0 on every read but the last and 1 on the last. Each byte read is delivered on `rdData`, in order.
- R5: With `REP_START`=0 the read turnaround is stop then start. With `REP_START`=1 it is a start alone.
- R6: The device address used on the bus is `chipAddr | ((regAddr >> 8*addrLen) & OVF_MASK)`. `addrLen` is unchanged by this merge.
- R7: A not-acknowledge on a device byte (write or read form) or on any register-address byte sends stop next, skips all further bytes and ends with `errNack`=1.
- R8: A write (`opSel` 1) takes `byteCount` bytes (1 to 256) from the write stream in order and writes each one. Every not-acknowledged data byte adds one to `failCount`, and the transfer carries on with `errNack`=0.
- R9: Every transaction, aborted or not, ends with a stop command. `done` pulses for one cycle after that stop completes. `busy` is high from the cycle after the accepted `startReq` to the cycle after `done`.
- R10: A `startReq` while `busy` is high is ignored and leaves the running transaction unchanged.
- R11: `rdValid` and `rdData` hold steady until `rdReady` is seen. `wrReady` is only high while busy.
- R12: The engine receives one-cycle `engReq` pulses, at most one outstanding, each answered by an `engDone` pulse. `engOp` codes are 1 start, 2 stop, 3 write, 4 read. For a write, `engAckSeen`=1 means acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | Request a transaction (sampled when idle) |
| opSel | input | 2 | 0 probe, 1 write, 2 read, 3 probe |
| chipAddr | input | 7 | Device address |
| regAddr | input | 8*ADDR_BYTES | Register address |
| addrLen | input | clog2(ADDR_BYTES+1) | Register address bytes to send |
| byteCount | input | CNT_W | Data bytes, 1 to 256 |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| errNack | output | 1 | Device or address byte not acknowledged |
| failCount | output | CNT_W | Not-acknowledged write data bytes |
| wrData | input | 8 | Write stream data |
| wrValid | input | 1 | Write stream valid |
| wrReady | output | 1 | Write stream ready |
| rdData | output | 8 | Read stream data |
| rdValid | output | 1 | Read stream valid |
| rdReady | input | 1 | Read stream ready |
| engReq | output | 1 | Command pulse to the byte engine |
| engOp | output | 3 | Engine command code |
| engTxByte | output | 8 | Byte to write |
| engSendNack | output | 1 | Send not-acknowledge after this read |
| engDone | input | 1 | Engine finished the command |
| engAckSeen | input | 1 | Written byte was acknowledged |
| engRxByte | input | 8 | Byte read by the engine |

## Verification
The bench builds two copies side by side on the same stimulus. One uses `OVF_MASK`=3 with the stop-then-start turnaround. The other uses `OVF_MASK`=0 with the repeated start. Every read therefore exercises both turnaround orders, and the same request shows the folded and the unfolded device address at once. Engine models with per-byte not-acknowledge masks and random stream stalls reach the abort paths at each byte position, the data failure count and the read hold under backpressure.

// File: rtl/eeprom_seq_pkg.sv
package eeprom_seq_pkg;

  typedef enum logic [2:0] {
    ENG_NONE  = 3'd0,
    ENG_START = 3'd1,
    ENG_STOP  = 3'd2,
    ENG_WRITE = 3'd3,
    ENG_READ  = 3'd4
  } engOp_e;

  typedef enum logic [1:0] {
    TXN_PROBE = 2'd0,
    TXN_WRITE = 2'd1,
    TXN_READ  = 2'd2
  } txnOp_e;

  typedef enum logic [1:0] {
    BSEL_CHIPW,
    BSEL_CHIPR,
    BSEL_ADDR,
    BSEL_DATA
  } byteSel_e;

  // strobes from the control FSM into the datapath
  typedef struct packed {
    logic     latch;
    logic     stepAddr;
    logic     stepData;
    logic     takeWr;
    logic     captureRx;
    logic     countFail;
    logic     flagErr;
    byteSel_e sel;
  } ctrlStrobe_t;

endpackage

// File: rtl/seq_datapath.sv
module seq_datapath
  import eeprom_seq_pkg::*;
#(
  parameter int       ADDR_BYTES = 4,
  parameter int       CNT_W      = 9,
  parameter int       ALEN_W     = 3,
  parameter bit [6:0] OVF_MASK   = 7'h00
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrlStrobe_t             ctrl,
  input  logic                    busy,
  input  logic                    startReq,
  input  logic [1:0]              opSel,
  input  logic [6:0]              chipAddr,
  input  logic [8*ADDR_BYTES-1:0] regAddr,
  input  logic [ALEN_W-1:0]       addrLen,
  input  logic [CNT_W-1:0]        byteCount,
  input  logic [7:0]              wrData,
  input  logic [7:0]              engRxByte,
  output logic [1:0]              opQ,
  output logic                    addrNone,
  output logic                    addrLast,
  output logic                    dataLast,
  output logic [7:0]              txByte,
  output logic [7:0]              rdData,
  output logic [CNT_W-1:0]        failCount,
  output logic                    errFlag
);

  localparam int AW = 8 * ADDR_BYTES;

  logic [6:0]        chipQ;
  logic [AW-1:0]     addrSh;
  logic [ALEN_W-1:0] addrLeft;
  logic [CNT_W-1:0]  dataLeft;
  logic [7:0]        wrQ;
  logic [7:0]        rxQ;
  logic [AW+7:0]     hiBits;
  logic [6:0]        chipFold;

  // bits above the transmitted address bytes, merged into the device address
  assign hiBits   = {8'h00, regAddr} >> {addrLen, 3'b000};
  assign chipFold = chipAddr | (hiBits[6:0] & OVF_MASK);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chipQ     <= '0;
      opQ       <= '0;
      addrSh    <= '0;
      addrLeft  <= '0;
      dataLeft  <= '0;
      wrQ       <= '0;
      rxQ       <= '0;
      failCount <= '0;
      errFlag   <= 1'b0;
    end else begin
      if (ctrl.latch) begin
        chipQ     <= chipFold;
        opQ       <= opSel;
        addrSh    <= regAddr << (8 * (ADDR_BYTES - int'(addrLen)));
        addrLeft  <= addrLen;
        dataLeft  <= byteCount;
        failCount <= '0;
        errFlag   <= 1'b0;
      end
      if (ctrl.stepAddr) begin
        addrSh   <= addrSh << 8;
        addrLeft <= addrLeft - 1'b1;
      end
      if (ctrl.stepData)  dataLeft  <= dataLeft - 1'b1;
      if (ctrl.takeWr)    wrQ       <= wrData;
      if (ctrl.captureRx) rxQ       <= engRxByte;
      if (ctrl.countFail) failCount <= failCount + 1'b1;
      if (ctrl.flagErr)   errFlag   <= 1'b1;
    end
  end

  assign addrNone = (addrLeft == '0);
  assign addrLast = (addrLeft == ALEN_W'(1));
  assign dataLast = (dataLeft == CNT_W'(1));
  assign rdData   = rxQ;

  always_comb begin
    case (ctrl.sel)
      BSEL_CHIPR: txByte = {chipQ, 1'b1};
      BSEL_ADDR:  txByte = addrSh[AW-1 -: 8];
      BSEL_DATA:  txByte = wrQ;
      default:    txByte = {chipQ, 1'b0};
    endcase
  end

  // R10: a request during a transaction leaves the latched request alone
  a_r10_busy_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startReq) |=> ($stable(chipQ) && $stable(opQ)));

endmodule

// File: rtl/seq_control.sv
module seq_control
  import eeprom_seq_pkg::*;
#(
  parameter bit REP_START = 1'b0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic [1:0]  opQ,
  input  logic        addrNone,
  input  logic        addrLast,
  input  logic        dataLast,
  input  logic        wrValid,
  input  logic        rdReady,
  input  logic        engDone,
  input  logic        engAckSeen,
  output ctrlStrobe_t ctrl,
  output logic        busy,
  output logic        done,
  output logic        wrReady,
  output logic        rdValid,
  output logic        engReq,
  output logic        engSendNack,
  output engOp_e      engOp
);

  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_CHIPW, ST_ADDR, ST_TSTOP, ST_TSTART, ST_CHIPR,
    ST_WFETCH, ST_WSEND, ST_RREAD, ST_RHAND, ST_STOP, ST_DONE
  } state_e;

  state_e state, nextState, turnState;
  logic   pend, fin, isRead, isProbe;

  assign isRead    = (opQ == TXN_READ);
  assign isProbe   = (opQ == TXN_PROBE) || (opQ == 2'd3);
  assign turnState = REP_START ? ST_TSTART : ST_TSTOP;

  always_comb begin
    case (state)
      ST_START, ST_TSTART:                 engOp = ENG_START;
      ST_STOP, ST_TSTOP:                   engOp = ENG_STOP;
      ST_CHIPW, ST_ADDR, ST_CHIPR, ST_WSEND: engOp = ENG_WRITE;
      ST_RREAD:                            engOp = ENG_READ;
      default:                             engOp = ENG_NONE;
    endcase
  end

  assign engReq      = (engOp != ENG_NONE) && !pend;
  assign fin         = pend && engDone;
  assign engSendNack = (state == ST_RREAD) && dataLast;
  assign busy        = (state != ST_IDLE);
  assign done        = (state == ST_DONE);
  assign wrReady     = (state == ST_WFETCH);
  assign rdValid     = (state == ST_RHAND);

  always_comb begin
    ctrl      = '0;
    nextState = state;
    case (state)
      ST_CHIPR: ctrl.sel = BSEL_CHIPR;
      ST_ADDR:  ctrl.sel = BSEL_ADDR;
      ST_WSEND: ctrl.sel = BSEL_DATA;
      default:  ctrl.sel = BSEL_CHIPW;
    endcase
    case (state)
      ST_IDLE: if (startReq) begin
        ctrl.latch = 1'b1;
        nextState  = ST_START;
      end
      ST_START: if (fin) nextState = (isRead && addrNone) ? ST_CHIPR : ST_CHIPW;
      ST_CHIPW: if (fin) begin
        if (!engAckSeen) begin
          ctrl.flagErr = 1'b1;
          nextState    = ST_STOP;
        end else if (isProbe)   nextState = ST_STOP;
        else if (!addrNone)     nextState = ST_ADDR;
        else if (isRead)        nextState = turnState;
        else                    nextState = ST_WFETCH;
      end
      ST_ADDR: if (fin) begin
        ctrl.stepAddr = 1'b1;
        if (!engAckSeen) begin
          ctrl.flagErr = 1'b1;
          nextState    = ST_STOP;
        end else if (addrLast) nextState = isRead ? turnState : ST_WFETCH;
      end
      ST_TSTOP:  if (fin) nextState = ST_TSTART;
      ST_TSTART: if (fin) nextState = ST_CHIPR;
      ST_CHIPR: if (fin) begin
        if (!engAckSeen) begin
          ctrl.flagErr = 1'b1;
          nextState    = ST_STOP;
        end else nextState = ST_RREAD;
      end
      ST_WFETCH: if (wrValid) begin
        ctrl.takeWr = 1'b1;
        nextState   = ST_WSEND;
      end
      ST_WSEND: if (fin) begin
        ctrl.countFail = !engAckSeen;
        ctrl.stepData  = 1'b1;
        nextState      = dataLast ? ST_STOP : ST_WFETCH;
      end
      ST_RREAD: if (fin) begin
        ctrl.captureRx = 1'b1;
        nextState      = ST_RHAND;
      end
      ST_RHAND: if (rdReady) begin
        ctrl.stepData = 1'b1;
        nextState     = dataLast ? ST_STOP : ST_RREAD;
      end
      ST_STOP: if (fin) nextState = ST_DONE;
      ST_DONE: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      pend  <= 1'b0;
    end else begin
      state <= nextState;
      if (engReq)       pend <= 1'b1;
      else if (engDone) pend <= 1'b0;
    end
  end

  // R12: a command stays outstanding until the engine answers
  a_r12_single_outstanding: assert property (@(posedge clk) disable iff (!rstN)
    engReq |=> !engReq);

  // R9: completion only follows a finished stop command
  a_r9_done_after_stop: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(engOp == ENG_STOP && engDone));

endmodule

// File: rtl/eeprom_txn_seq.sv
module eeprom_txn_seq
  import eeprom_seq_pkg::*;
#(
  parameter int       ADDR_BYTES = 4,
  parameter int       CNT_W      = 9,
  parameter bit [6:0] OVF_MASK   = 7'h00,
  parameter bit       REP_START  = 1'b0,
  localparam int      ALEN_W     = $clog2(ADDR_BYTES + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    startReq,
  input  logic [1:0]              opSel,
  input  logic [6:0]              chipAddr,
  input  logic [8*ADDR_BYTES-1:0] regAddr,
  input  logic [ALEN_W-1:0]       addrLen,
  input  logic [CNT_W-1:0]        byteCount,
  output logic                    busy,
  output logic                    done,
  output logic                    errNack,
  output logic [CNT_W-1:0]        failCount,
  input  logic [7:0]              wrData,
  input  logic                    wrValid,
  output logic                    wrReady,
  output logic [7:0]              rdData,
  output logic                    rdValid,
  input  logic                    rdReady,
  output logic                    engReq,
  output logic [2:0]              engOp,
  output logic [7:0]              engTxByte,
  output logic                    engSendNack,
  input  logic                    engDone,
  input  logic                    engAckSeen,
  input  logic [7:0]              engRxByte
);

  ctrlStrobe_t ctrl;
  engOp_e      engOpE;
  logic [1:0]  opQ;
  logic        addrNone, addrLast, dataLast;

  seq_control #(.REP_START(REP_START)) u_control (
    .clk(clk), .rstN(rstN), .startReq(startReq), .opQ(opQ),
    .addrNone(addrNone), .addrLast(addrLast), .dataLast(dataLast),
    .wrValid(wrValid), .rdReady(rdReady), .engDone(engDone), .engAckSeen(engAckSeen),
    .ctrl(ctrl), .busy(busy), .done(done), .wrReady(wrReady), .rdValid(rdValid),
    .engReq(engReq), .engSendNack(engSendNack), .engOp(engOpE)
  );

  seq_datapath #(
    .ADDR_BYTES(ADDR_BYTES), .CNT_W(CNT_W), .ALEN_W(ALEN_W), .OVF_MASK(OVF_MASK)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .busy(busy), .startReq(startReq),
    .opSel(opSel), .chipAddr(chipAddr), .regAddr(regAddr), .addrLen(addrLen),
    .byteCount(byteCount), .wrData(wrData), .engRxByte(engRxByte),
    .opQ(opQ), .addrNone(addrNone), .addrLast(addrLast), .dataLast(dataLast),
    .txByte(engTxByte), .rdData(rdData), .failCount(failCount), .errFlag(errNack)
  );

  assign engOp = engOpE;

  // R11: read byte held under backpressure
  a_r11_rd_hold: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !rdReady) |=> (rdValid && $stable(rdData)));

  // R11: write stream only accepted inside a transaction
  a_r11_wr_ready_busy: assert property (@(posedge clk) disable iff (!rstN)
    wrReady |-> busy);

  // R7: the error flag rises exactly as the stop command is issued
  a_r7_err_then_stop: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errNack) |-> (engOpE == ENG_STOP));

endmodule

// File: tb/test_eeprom_txn_seq.sv
`timescale 1ns/1ps

// Byte engine and stream model for one sequencer copy; all action on the falling edge.
module seq_env (
  input  logic       clk,
  input  logic       startReq,
  input  logic       busy,
  input  logic       done,
  input  logic       engReq,
  input  logic [2:0] engOp,
  input  logic [7:0] engTxByte,
  input  logic       engSendNack,
  output logic       engDone,
  output logic       engAckSeen,
  output logic [7:0] engRxByte,
  output logic [7:0] wrData,
  output logic       wrValid,
  input  logic       wrReady,
  input  logic [7:0] rdData,
  input  logic       rdValid,
  output logic       rdReady
);
  int            logQ[$];
  byte unsigned  wrSrc[$];
  byte unsigned  rdGot[$];
  logic [31:0]   nackMask = 0;
  logic          stallOn = 0;
  int            wrIdx = 0, wrCmd = 0, rdCmd = 0, respCnt = 0;
  int            busyBad = 0, reqBad = 0;
  logic          expBusy = 0, wrFire = 0, pAck = 1;
  logic [7:0]    pRx = 0;
  logic [7:0]    lfsr = 8'hA5;

  initial begin
    engDone = 0; engAckSeen = 0; engRxByte = 0;
    wrData = 0; wrValid = 0; rdReady = 1;
  end

  task automatic clear();
    logQ.delete(); rdGot.delete(); wrSrc.delete();
    wrIdx = 0; wrCmd = 0; rdCmd = 0; wrFire = 0;
  endtask

  always @(negedge clk) begin
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    // per-clock reference for busy (R9) and request protocol (R12)
    if (busy !== expBusy) busyBad++;
    if (!expBusy && startReq) expBusy = 1;
    else if (expBusy && done) expBusy = 0;
    if (engReq && (!busy || respCnt != 0)) reqBad++;
    // engine: answer two cycles after the request
    engDone = 0;
    if (respCnt == 1) begin
      engDone = 1; engAckSeen = pAck; engRxByte = pRx; respCnt = 0;
    end else if (respCnt > 1) begin
      respCnt--;
    end else if (engReq) begin
      logQ.push_back(int'(engOp) * 512 + ((engOp == 3'd4) ? int'(engSendNack) * 256 : 0)
                     + ((engOp == 3'd3) ? int'(engTxByte) : 0));
      pAck = 1;
      if (engOp == 3'd3) begin
        pAck = !(wrCmd < 32 && nackMask[wrCmd]);
        wrCmd++;
      end
      if (engOp == 3'd4) begin
        pRx = 8'(8'h30 + rdCmd);
        rdCmd++;
      end
      respCnt = 2;
    end
    // write stream source
    if (wrFire) wrIdx++;
    wrValid = (wrIdx < wrSrc.size()) && (!stallOn || lfsr[0]);
    wrData  = wrValid ? wrSrc[wrIdx] : 8'h00;
    wrFire  = wrValid && wrReady;
    // read stream sink
    rdReady = !stallOn || lfsr[1];
    if (rdValid && rdReady) rdGot.push_back(rdData);
  end
endmodule

module test_eeprom_txn_seq;
  logic clk = 0;
  always #2 clk = ~clk;

  logic        rstN, startReq;
  logic [1:0]  opSel;
  logic [6:0]  chipAddr;
  logic [31:0] regAddr;
  logic [2:0]  addrLen;
  logic [8:0]  byteCount;

  logic busyA, doneA, errA, wrValidA, wrReadyA, rdValidA, rdReadyA, engReqA, engNackA, engDoneA, engAckA;
  logic [8:0] failA;
  logic [7:0] wrDataA, rdDataA, engTxA, engRxA;
  logic [2:0] engOpA;
  logic busyB, doneB, errB, wrValidB, wrReadyB, rdValidB, rdReadyB, engReqB, engNackB, engDoneB, engAckB;
  logic [8:0] failB;
  logic [7:0] wrDataB, rdDataB, engTxB, engRxB;
  logic [2:0] engOpB;

  eeprom_txn_seq #(.OVF_MASK(7'h03), .REP_START(1'b0)) i_eeprom_txn_seq (
    .clk(clk), .rstN(rstN), .startReq(startReq), .opSel(opSel), .chipAddr(chipAddr),
    .regAddr(regAddr), .addrLen(addrLen), .byteCount(byteCount), .busy(busyA), .done(doneA),
    .errNack(errA), .failCount(failA), .wrData(wrDataA), .wrValid(wrValidA), .wrReady(wrReadyA),
    .rdData(rdDataA), .rdValid(rdValidA), .rdReady(rdReadyA), .engReq(engReqA), .engOp(engOpA),
    .engTxByte(engTxA), .engSendNack(engNackA), .engDone(engDoneA), .engAckSeen(engAckA),
    .engRxByte(engRxA));

  eeprom_txn_seq #(.OVF_MASK(7'h00), .REP_START(1'b1)) i_eeprom_txn_seq_rs (
    .clk(clk), .rstN(rstN), .startReq(startReq), .opSel(opSel), .chipAddr(chipAddr),
    .regAddr(regAddr), .addrLen(addrLen), .byteCount(byteCount), .busy(busyB), .done(doneB),
    .errNack(errB), .failCount(failB), .wrData(wrDataB), .wrValid(wrValidB), .wrReady(wrReadyB),
    .rdData(rdDataB), .rdValid(rdValidB), .rdReady(rdReadyB), .engReq(engReqB), .engOp(engOpB),
    .engTxByte(engTxB), .engSendNack(engNackB), .engDone(engDoneB), .engAckSeen(engAckB),
    .engRxByte(engRxB));

  seq_env envA (.clk(clk), .startReq(startReq), .busy(busyA), .done(doneA), .engReq(engReqA),
    .engOp(engOpA), .engTxByte(engTxA), .engSendNack(engNackA), .engDone(engDoneA),
    .engAckSeen(engAckA), .engRxByte(engRxA), .wrData(wrDataA), .wrValid(wrValidA),
    .wrReady(wrReadyA), .rdData(rdDataA), .rdValid(rdValidA), .rdReady(rdReadyA));
  seq_env envB (.clk(clk), .startReq(startReq), .busy(busyB), .done(doneB), .engReq(engReqB),
    .engOp(engOpB), .engTxByte(engTxB), .engSendNack(engNackB), .engDone(engDoneB),
    .engAckSeen(engAckB), .engRxByte(engRxB), .wrData(wrDataB), .wrValid(wrValidB),
    .wrReady(wrReadyB), .rdData(rdDataB), .rdValid(rdValidB), .rdReady(rdReadyB));

  int total = 0, bad = 0;
  int doneCnt[2] = '{0, 0};
  int errAt[2], failAt[2];

  always @(negedge clk) begin
    if (doneA) begin doneCnt[0]++; errAt[0] = errA; failAt[0] = failA; end
    if (doneB) begin doneCnt[1]++; errAt[1] = errB; failAt[1] = failB; end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // current request
  int curOp, curChip, curAlen, curLen, curNack;
  longint unsigned curAddr;
  int expQ[$];
  byte unsigned expRd[$];
  bit expErr;
  int expFail, expWr;

  function automatic byte unsigned wrPat(int k);
    return 8'(k * 37 + 5);
  endfunction

  task automatic buildExp(input int g);
    int c, wi, mask;
    bit rep, stop;
    mask = (g == 0) ? 3 : 0;
    rep  = (g == 1);
    c = curChip | (int'((curAddr >> (8 * curAlen)) & 64'hFF) & mask);
    expQ.delete(); expRd.delete();
    expErr = 0; expFail = 0; expWr = 0; wi = 0; stop = 0;
    expQ.push_back(1 * 512);
    if (!(curOp == 2 && curAlen == 0)) begin
      expQ.push_back(3 * 512 + ((c << 1) & 255));
      if (wi < 32 && curNack[wi]) begin expErr = 1; stop = 1; end
      wi++;
      if (!stop && (curOp == 0 || curOp == 3)) stop = 1;
      for (int i = curAlen - 1; i >= 0 && !stop; i--) begin
        expQ.push_back(3 * 512 + int'((curAddr >> (8 * i)) & 64'hFF));
        if (wi < 32 && curNack[wi]) begin expErr = 1; stop = 1; end
        wi++;
      end
      if (!stop && curOp == 1) begin
        for (int k = 0; k < curLen; k++) begin
          expQ.push_back(3 * 512 + wrPat(k));
          expWr++;
          if (wi < 32 && curNack[wi]) expFail++;
          wi++;
        end
        stop = 1;
      end
      if (!stop) begin
        if (!rep) expQ.push_back(2 * 512);
        expQ.push_back(1 * 512);
      end
    end
    if (!stop) begin
      expQ.push_back(3 * 512 + (((c << 1) | 1) & 255));
      if (wi < 32 && curNack[wi]) begin expErr = 1; stop = 1; end
      wi++;
      for (int k = 0; k < curLen && !stop; k++) begin
        expQ.push_back(4 * 512 + ((k == curLen - 1) ? 256 : 0));
        expRd.push_back(8'(8'h30 + k));
      end
    end
    expQ.push_back(2 * 512);
  endtask

  task automatic compareG(input int g, input string req);
    int act[$];
    byte unsigned got[$];
    int wIdx;
    bit same;
    string tag;
    tag = (g == 0) ? "stop-start/mask3" : "repstart/mask0";
    if (g == 0) begin act = envA.logQ; got = envA.rdGot; wIdx = envA.wrIdx; end
    else        begin act = envB.logQ; got = envB.rdGot; wIdx = envB.wrIdx; end
    buildExp(g);
    chk(act.size() == expQ.size(), req, {tag, " command count"}, act.size(), expQ.size());
    same = (act.size() == expQ.size());
    for (int i = 0; i < act.size() && same; i++) begin
      if (act[i] != expQ[i]) begin
        chk(0, req, $sformatf("%s command %0d", tag, i), act[i], expQ[i]);
        same = 0;
      end
    end
    chk(act.size() > 0 && act[act.size() - 1] == 2 * 512, "R9",
        {tag, " last command is stop"}, (act.size() > 0) ? act[act.size() - 1] : -1, 2 * 512);
    chk(errAt[g] == int'(expErr), req, {tag, " errNack"}, errAt[g], expErr);
    if (curOp == 1) chk(failAt[g] == expFail, "R8", {tag, " failCount"}, failAt[g], expFail);
    chk(wIdx == expWr, req, {tag, " write bytes taken"}, wIdx, expWr);
    if (curOp == 2) begin
      same = (got.size() == expRd.size());
      chk(same, "R4", {tag, " read byte count"}, got.size(), expRd.size());
      for (int i = 0; i < got.size() && same; i++)
        if (got[i] != expRd[i]) begin
          chk(0, "R4", $sformatf("%s read byte %0d", tag, i), got[i], expRd[i]);
          same = 0;
        end
    end
  endtask

  task automatic runTxn(input string req, input int op, input int chip, input longint unsigned addr,
                        input int alen, input int len, input int nm, input bit stall,
                        input bit poke);
    int base0, base1, t;
    curOp = op; curChip = chip; curAddr = addr; curAlen = alen; curLen = len; curNack = nm;
    envA.clear(); envB.clear();
    envA.nackMask = nm; envB.nackMask = nm;
    envA.stallOn = stall; envB.stallOn = stall;
    if (op == 1)
      for (int k = 0; k < len; k++) begin
        envA.wrSrc.push_back(wrPat(k));
        envB.wrSrc.push_back(wrPat(k));
      end
    base0 = doneCnt[0]; base1 = doneCnt[1];
    @(posedge clk); #1;
    opSel = 2'(op); chipAddr = 7'(chip); regAddr = 32'(addr);
    addrLen = 3'(alen); byteCount = 9'(len); startReq = 1;
    @(posedge clk); #1;
    startReq = 0;
    if (poke) begin
      repeat (10) @(posedge clk);
      #1;
      opSel = 2'd0; chipAddr = 7'h11; regAddr = 32'h0; addrLen = 3'd0; byteCount = 9'd1;
      startReq = 1;
      @(posedge clk); #1;
      startReq = 0;
    end
    t = 0;
    while ((doneCnt[0] == base0 || doneCnt[1] == base1) && t < 20000) begin
      @(posedge clk); t++;
    end
    chk(t < 20000, req, "transaction timeout", t, 0);
    repeat (4) @(posedge clk);
    #1;
    chk(doneCnt[0] == base0 + 1 && doneCnt[1] == base1 + 1, "R9", "one done pulse each",
        doneCnt[0] - base0 + doneCnt[1] - base1, 2);
    compareG(0, req);
    compareG(1, req);
  endtask

  initial begin
    #800000;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 0; startReq = 0; opSel = 0; chipAddr = 0; regAddr = 0; addrLen = 0; byteCount = 1;
    repeat (3) @(posedge clk);
    #1;
    chk(!busyA && !busyB && !doneA && !doneB && !engReqA && !engReqB, "R9",
        "reset state quiet", {busyA, busyB, doneA, doneB, engReqA, engReqB}, 0);
    rstN = 1;
    repeat (2) @(posedge clk);

    runTxn("R1", 0, 'h50, 0, 0, 1, 0, 0, 0);                        // probe, present
    runTxn("R1", 0, 'h51, 0, 2, 1, 1, 0, 0);                        // probe, absent (R7 flag)
    runTxn("R2", 1, 'h50, 'h1234, 2, 3, 0, 0, 0);                    // write, 2 address bytes
    runTxn("R8", 1, 'h50, 'h1234, 2, 3, (1 << 3) | (1 << 5), 0, 0);  // data nacks counted
    runTxn("R7", 1, 'h50, 'h1234, 2, 3, 1 << 1, 0, 0);               // address nack aborts
    runTxn("R6", 2, 'h50, 'h2AB, 1, 4, 0, 1, 0);                     // overflow fold, R5, R11 stalls
    runTxn("R3", 2, 'h3C, 'h0, 0, 1, 0, 0, 0);                       // read with no address phase
    runTxn("R5", 2, 'h50, 'hDEADBEEF, 4, 2, 0, 0, 0);                // four address bytes
    runTxn("R7", 2, 'h50, 'h10, 1, 2, 1, 0, 0);                      // device byte nack
    runTxn("R7", 2, 'h50, 'h1020, 2, 2, 1 << 3, 0, 0);               // read-form device nack
    runTxn("R10", 2, 'h50, 'h77, 1, 3, 0, 0, 1);                     // start while busy
    runTxn("R8", 1, 'h22, 'h00ABCDEF, 3, 20, 1 << 10, 1, 0);         // long write, stalled stream
    runTxn("R2", 1, 'h50, 'h0, 0, 2, 0, 0, 0);                       // write with alen 0
    runTxn("R4", 2, 'h50, 'h3FF, 1, 256, 0, 0, 0);                   // max length read

    chk(envA.busyBad == 0, "R9", "busy per-clock mismatches A", envA.busyBad, 0);
    chk(envB.busyBad == 0, "R9", "busy per-clock mismatches B", envB.busyBad, 0);
    chk(envA.reqBad == 0, "R12", "engine request protocol A", envA.reqBad, 0);
    chk(envB.reqBad == 0, "R12", "engine request protocol B", envB.reqBad, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule